// File: doc/BRIEF.md
# UART Interrupt and Line-Status Logic

This block produces the interrupt and line-status behaviour of one channel of a FIFO-buffered UART. It sees the receive and transmit FIFOs only through one-cycle event strobes: a character entering or leaving, an overrun, the transmit shift register's empty flag and the error flags of each received character. From these strobes it keeps its own occupancy counts and a per-entry record of errored characters. From that state it presents an 8-bit line status word, a 4-bit interrupt identification code and an active-high interrupt line.

The host configures the block with a FIFO enable, three interrupt enables and a receive trigger threshold. Its register reads reach the block as strobes: a line-status read and an interrupt-identification read. Both have side effects. No data moves through the block, so every pin is a plain control or status signal. Strobes are sampled on each rising clock edge and need no handshake. Outputs come from registered state, so an event shows in the cycle after its strobe.

Top module: `uart_irq_status`

## Requirements
- R1: After reset the line status is 0x60 when `tsr_empty` is high, the code is 4'b0001 and `irq` is low.
- R2: Status bit 0 rises in the cycle after a character is accepted into the receive FIFO. It stays high while at least one character remains and falls when the last one is popped.
- R3: With the FIFO enabled and `ier[0]` set, the receive-data code 4'b0100 is reported while the receive count is at least `rx_trig`, and it drops as soon as the count falls below. A threshold of 0 acts as 1.
- R4: With `fifo_en` low the receive side holds one character. Further pushes are ignored, and the receive-data interrupt fires at one character whatever `rx_trig` holds.
- R5: Status bits 1 to 4 are sticky. Bit 1 is set by `rx_overrun`. Bits 2, 3 and 4 are set by an accepted character whose `rx_flags` bit 0 (parity), bit 1 (framing) or bit 2 (break) is high. A line-status read clears them, but an event in the same cycle as the read is kept.
- R6: Status bit 7 is high while any character held in the receive FIFO carries an error. A line-status read clears it for one cycle; it then returns if errored characters remain.
- R7: Status bit 5 is high when the transmit FIFO is empty. Bit 6 is high when that FIFO is empty and `tsr_empty` is high.
- R8: The transmit-empty source becomes pending when the transmit FIFO drains to empty, or when `ier[1]` rises while that FIFO is empty. It reports code 4'b0010 when `ier[1]` is set. A transmit push clears it, and so does an identification read made while 4'b0010 is the reported code.
- R9: With `ier[2]` set, any of status bits 1 to 4 reports code 4'b0110. An identification read does not clear it.
- R10: Only the highest-priority active source is reported: line status, then receive data, then transmit empty. No source gives 4'b0001, and `irq` is high exactly when code bit 0 is low.
- R11: With `ier` all zero (polled mode), `irq` stays low and the code stays 4'b0001, while every status bit keeps updating.
- R12: A receive push while the FIFO is full and a pop from an empty FIFO are ignored. The same holds on the transmit side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | FIFO mode enable |
| ier | input | 3 | Interrupt enables: bit0 receive data, bit1 transmit empty, bit2 line status |
| rx_trig | input | 5 | Receive trigger threshold in characters |
| rx_push | input | 1 | Character moved from the shift register into the receive FIFO |
| rx_flags | input | 3 | Errors of the pushed character: bit0 parity, bit1 framing, bit2 break |
| rx_pop | input | 1 | Host read of one receive character |
| rx_overrun | input | 1 | Overrun event strobe |
| tx_push | input | 1 | Host write to the transmit holding register |
| tx_pop | input | 1 | Shifter took one transmit character |
| tsr_empty | input | 1 | Transmit shift register is idle |
| lsr_rd | input | 1 | Line status read strobe |
| isr_rd | input | 1 | Interrupt identification read strobe |
| lsr | output | 8 | Line status word |
| isr_code | output | 4 | Interrupt identification code |
| irq | output | 1 | Active-high interrupt |

## Verification
The hardest state to reach is an errored character sitting behind clean ones in the receive FIFO. It has to stay there while the line-status read clears bit 7, and bit 7 must come back before the character is finally popped. The vector table pushes clean characters, pops one and then pushes an errored one. It then reads the line status and pops one character at a time, checking bit 7 at each step. It also overlaps a line-status read with a new error and a pending transmit-empty source with a higher-priority line-status source, so that both the retained-event and the priority paths are forced.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef enum logic [3:0] {
    ISR_NONE = 4'b0001,
    ISR_RLS  = 4'b0110,
    ISR_RDA  = 4'b0100,
    ISR_THRE = 4'b0010
  } isr_code_e;

  localparam int LS_DR   = 0;
  localparam int LS_OE   = 1;
  localparam int LS_PE   = 2;
  localparam int LS_FE   = 3;
  localparam int LS_BI   = 4;
  localparam int LS_THRE = 5;
  localparam int LS_TEMT = 6;
  localparam int LS_FERR = 7;

  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
  } rx_err_t;

endpackage

// File: rtl/rx_track.sv
module rx_track #(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic             push,
  input  logic             push_err,
  input  logic             pop,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] err_cnt,
  output logic             err_nz_nx,
  output logic             push_ok
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [DEPTH-1:0] flag;
  logic [CNT_W-1:0] cap, cnt_nx, err_nx;
  logic             pop_ok, pop_err;

  assign cap     = fifo_en ? CNT_W'(DEPTH) : CNT_W'(1);
  assign push_ok = push && (cnt < cap);
  assign pop_ok  = pop && (cnt != '0);
  assign pop_err = flag[rd_ptr];

  assign cnt_nx    = cnt + CNT_W'(push_ok) - CNT_W'(pop_ok);
  assign err_nx    = err_cnt + CNT_W'(push_ok && push_err) - CNT_W'(pop_ok && pop_err);
  assign err_nz_nx = (err_nx != '0);

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      err_cnt <= '0;
      wr_ptr  <= '0;
      rd_ptr  <= '0;
    end else begin
      cnt     <= cnt_nx;
      err_cnt <= err_nx;
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
    end
  end

  // one error flag per slot, written alongside the pushed character
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        flag[i] <= 1'b0;
      else if (push_ok && (wr_ptr == PTR_W'(i)))
        flag[i] <= push_err;
    end
  end

  p_cnt_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH));

  p_err_within_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_cnt <= cnt);

  p_full_drop_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && push && !pop && cnt == CNT_W'(DEPTH)) |=> (cnt == CNT_W'(DEPTH)));

  p_empty_pop_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && cnt == '0) |=> (cnt == '0));

  p_single_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && cnt != '0 && !pop) |=> (cnt == $past(cnt)));

endmodule

// File: rtl/tx_track.sv
module tx_track #(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic pop,
  output logic empty,
  output logic drained
);

  logic [CNT_W-1:0] cnt, cnt_nx;
  logic             push_ok, pop_ok;

  assign push_ok = push && (cnt != CNT_W'(DEPTH));
  assign pop_ok  = pop && (cnt != '0);
  assign cnt_nx  = cnt + CNT_W'(push_ok) - CNT_W'(pop_ok);
  assign empty   = (cnt == '0);
  assign drained = (cnt != '0) && (cnt_nx == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nx;
  end

  p_drain_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    drained |=> empty);

  p_push_fills_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> !empty);

endmodule

// File: rtl/lsr_flags.sv
module lsr_flags
  import uart_irq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    overrun,
  input  logic    push_ok,
  input  rx_err_t flags,
  input  logic    rd,
  input  logic    err_nz_nx,
  output logic    oe,
  output logic    pe,
  output logic    fe,
  output logic    bi,
  output logic    fifo_err
);

  logic set_pe, set_fe, set_bi;

  assign set_pe = push_ok && flags.par;
  assign set_fe = push_ok && flags.frm;
  assign set_bi = push_ok && flags.brk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe       <= 1'b0;
      pe       <= 1'b0;
      fe       <= 1'b0;
      bi       <= 1'b0;
      fifo_err <= 1'b0;
    end else begin
      // a new event in the read cycle survives the clear
      oe       <= overrun || (oe && !rd);
      pe       <= set_pe  || (pe && !rd);
      fe       <= set_fe  || (fe && !rd);
      bi       <= set_bi  || (bi && !rd);
      fifo_err <= !rd && err_nz_nx;
    end
  end

  p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !overrun && !push_ok) |=> !(oe || pe || fe || bi));

  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (oe && !rd) |=> oe);

  p_ferr_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> !fifo_err);

endmodule

// File: rtl/irq_select.sv
module irq_select
  import uart_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] ier,
  input  logic       rls_any,
  input  logic       rda_hit,
  input  logic       tx_empty,
  input  logic       tx_drained,
  input  logic       tx_push,
  input  logic       isr_rd,
  output logic [3:0] code,
  output logic       irq
);

  logic      thre_pend, ier1_q, thre_set, thre_clr;
  isr_code_e sel;

  always_comb begin
    if (ier[2] && rls_any)        sel = ISR_RLS;
    else if (ier[0] && rda_hit)   sel = ISR_RDA;
    else if (ier[1] && thre_pend) sel = ISR_THRE;
    else                          sel = ISR_NONE;
  end

  assign code = sel;
  assign irq  = (sel != ISR_NONE);

  assign thre_set = tx_drained || (ier[1] && !ier1_q && tx_empty && !tx_push);
  assign thre_clr = tx_push || (isr_rd && sel == ISR_THRE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thre_pend <= 1'b0;
      ier1_q    <= 1'b0;
    end else begin
      ier1_q <= ier[1];
      if (thre_set)      thre_pend <= 1'b1;
      else if (thre_clr) thre_pend <= 1'b0;
    end
  end

  p_polled_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ier == 3'b000) |-> (!irq && code == 4'b0001));

  p_thre_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push |=> !thre_pend);

  p_rls_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ier[2] && rls_any) |-> (code == 4'b0110));

  p_irq_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq == !code[0]);

endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
  import uart_irq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic [2:0]       ier,
  input  logic [CNT_W-1:0] rx_trig,
  input  logic             rx_push,
  input  logic [2:0]       rx_flags,
  input  logic             rx_pop,
  input  logic             rx_overrun,
  input  logic             tx_push,
  input  logic             tx_pop,
  input  logic             tsr_empty,
  input  logic             lsr_rd,
  input  logic             isr_rd,
  output logic [7:0]       lsr,
  output logic [3:0]       isr_code,
  output logic             irq
);

  logic [CNT_W-1:0] rx_cnt, err_cnt, level;
  logic             err_nz_nx, rx_push_ok;
  logic             tx_empty, tx_drained;
  logic             oe, pe, fe, bi, fifo_err;
  logic             rda_hit;
  rx_err_t          flags;

  assign flags = rx_err_t'(rx_flags);

  rx_track #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
    .push(rx_push), .push_err(|rx_flags), .pop(rx_pop),
    .cnt(rx_cnt), .err_cnt(err_cnt), .err_nz_nx(err_nz_nx), .push_ok(rx_push_ok)
  );

  tx_track #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .pop(tx_pop),
    .empty(tx_empty), .drained(tx_drained)
  );

  lsr_flags u_lsr (
    .clk(clk), .rst_n(rst_n), .overrun(rx_overrun), .push_ok(rx_push_ok),
    .flags(flags), .rd(lsr_rd), .err_nz_nx(err_nz_nx),
    .oe(oe), .pe(pe), .fe(fe), .bi(bi), .fifo_err(fifo_err)
  );

  // threshold: zero acts as one; single-character mode forces one
  assign level   = (!fifo_en || rx_trig == '0) ? CNT_W'(1) : rx_trig;
  assign rda_hit = (rx_cnt >= level);

  irq_select u_irq (
    .clk(clk), .rst_n(rst_n), .ier(ier),
    .rls_any(oe || pe || fe || bi), .rda_hit(rda_hit),
    .tx_empty(tx_empty), .tx_drained(tx_drained), .tx_push(tx_push),
    .isr_rd(isr_rd), .code(isr_code), .irq(irq)
  );

  always_comb begin
    lsr          = '0;
    lsr[LS_DR]   = (rx_cnt != '0);
    lsr[LS_OE]   = oe;
    lsr[LS_PE]   = pe;
    lsr[LS_FE]   = fe;
    lsr[LS_BI]   = bi;
    lsr[LS_THRE] = tx_empty;
    lsr[LS_TEMT] = tx_empty && tsr_empty;
    lsr[LS_FERR] = fifo_err;
  end

  p_rda_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && ier == 3'b001 && rx_trig != '0 && rx_cnt >= rx_trig) |-> irq);

  p_temt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lsr[LS_TEMT] |-> lsr[LS_THRE]);

  p_ferr_has_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lsr[LS_FERR] |-> lsr[LS_DR]);

  p_dr_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && !rx_pop) |=> lsr[LS_DR]);

endmodule

// File: tb/sim_uart_irq_status.sv
module sim_uart_irq_status;

  localparam int DEPTH = 16;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int NVEC  = 25;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             fifo_en = 1'b1;
  logic [2:0]       ier = 3'b000;
  logic [CNT_W-1:0] rx_trig = CNT_W'(4);
  logic             rx_push = 1'b0, rx_pop = 1'b0, rx_overrun = 1'b0;
  logic [2:0]       rx_flags = 3'b000;
  logic             tx_push = 1'b0, tx_pop = 1'b0, tsr_empty = 1'b1;
  logic             lsr_rd = 1'b0, isr_rd = 1'b0;
  logic [7:0]       lsr;
  logic [3:0]       isr_code;
  logic             irq;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  uart_irq_status #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .ier(ier), .rx_trig(rx_trig),
    .rx_push(rx_push), .rx_flags(rx_flags), .rx_pop(rx_pop), .rx_overrun(rx_overrun),
    .tx_push(tx_push), .tx_pop(tx_pop), .tsr_empty(tsr_empty),
    .lsr_rd(lsr_rd), .isr_rd(isr_rd), .lsr(lsr), .isr_code(isr_code), .irq(irq)
  );

  // ops {rx_push, flags[2:0], rx_pop, tx_push, tx_pop, lsr_rd, isr_rd}, expected lsr, code
  // config: fifo_en=1, ier=111, rx_trig=4, tsr_empty=1
  localparam logic [20:0] VEC [NVEC] = '{
    {9'b0_000_0_1_0_0_0, 8'h00, 4'h1},  // R8 write clears pending, R7
    {9'b0_000_0_0_1_0_0, 8'h60, 4'h2},  // R8 drain sets pending
    {9'b0_000_0_0_0_0_1, 8'h60, 4'h1},  // R8 id read clears
    {9'b1_000_0_0_0_0_0, 8'h61, 4'h1},  // R2 data ready
    {9'b1_000_0_0_0_0_0, 8'h61, 4'h1},
    {9'b1_000_0_0_0_0_0, 8'h61, 4'h1},
    {9'b1_000_0_0_0_0_0, 8'h61, 4'h4},  // R3 trigger reached
    {9'b0_000_1_0_0_0_0, 8'h61, 4'h1},  // R3 below trigger
    {9'b1_001_0_0_0_0_0, 8'hE5, 4'h6},  // R5 parity, R6, R9
    {9'b0_000_0_0_0_1_0, 8'h61, 4'h4},  // R5 R6 read clears
    {9'b0_000_0_0_0_0_0, 8'hE1, 4'h4},  // R6 returns
    {9'b0_000_1_0_0_0_0, 8'hE1, 4'h1},
    {9'b0_000_1_0_0_0_0, 8'hE1, 4'h1},
    {9'b0_000_1_0_0_0_0, 8'hE1, 4'h1},
    {9'b0_000_1_0_0_0_0, 8'h60, 4'h1},  // R6 errored char gone, R2
    {9'b1_100_0_1_0_0_0, 8'h91, 4'h6},  // R5 break
    {9'b0_000_0_0_0_0_1, 8'h91, 4'h6},  // R9 id read keeps it
    {9'b0_000_0_0_1_0_0, 8'hF1, 4'h6},  // R10 priority over pending transmit
    {9'b0_000_0_0_0_1_0, 8'h61, 4'h2},  // R10 next source
    {9'b0_000_0_0_0_0_0, 8'hE1, 4'h2},  // R6
    {9'b0_000_1_0_0_0_0, 8'h60, 4'h2},
    {9'b0_000_0_0_0_0_1, 8'h60, 4'h1},  // R8
    {9'b1_011_0_0_0_1_0, 8'h6D, 4'h6},  // R5 event kept across read
    {9'b0_000_0_0_0_0_0, 8'hED, 4'h6},  // R6
    {9'b0_000_1_0_0_1_0, 8'h60, 4'h1}   // R5 R6 R2
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    rx_push = 1'b0; rx_flags = 3'b000; rx_pop = 1'b0; rx_overrun = 1'b0;
    tx_push = 1'b0; tx_pop = 1'b0; lsr_rd = 1'b0; isr_rd = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick();
    rst_n = 1'b1;
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 lsr", lsr, 8'h60);
    chk("R1 code", isr_code, 4'h1);
    chk("R1 irq", irq, 1'b0);
    // R7 shift register busy
    tsr_empty = 1'b0;
    #1;
    chk("R7 temt", lsr, 8'h20);
    tsr_empty = 1'b1;

    // table run
    ier = 3'b111;
    tick();
    chk("R8 enable with empty fifo", isr_code, 4'h2);
    for (int i = 0; i < NVEC; i++) begin
      {rx_push, rx_flags, rx_pop, tx_push, tx_pop, lsr_rd, isr_rd} = VEC[i][20:12];
      tick();
      chk($sformatf("R10 step %0d lsr", i), lsr, VEC[i][11:4]);
      chk($sformatf("R10 step %0d code", i), isr_code, VEC[i][3:0]);
      chk($sformatf("R10 step %0d irq", i), irq, !VEC[i][0]);
    end

    // R11 polled mode
    ier = 3'b000;
    do_reset();
    for (int k = 0; k < 4; k++) begin rx_push = 1'b1; tick(); end
    rx_push = 1'b1; rx_flags = 3'b001; tick();
    chk("R11 lsr live", lsr, 8'hE5);
    chk("R11 code", isr_code, 4'h1);
    chk("R11 irq", irq, 1'b0);

    // R3 threshold at depth, R12 full
    ier = 3'b001; rx_trig = CNT_W'(DEPTH);
    do_reset();
    for (int k = 0; k < DEPTH - 1; k++) begin rx_push = 1'b1; tick(); end
    chk("R3 one short", isr_code, 4'h1);
    rx_push = 1'b1; tick();
    chk("R3 full level", isr_code, 4'h4);
    rx_push = 1'b1; tick();   // ignored
    for (int k = 0; k < DEPTH - 1; k++) begin rx_pop = 1'b1; tick(); end
    chk("R12 one left", lsr[0], 1'b1);
    rx_pop = 1'b1; tick();
    chk("R12 full push ignored", lsr[0], 1'b0);
    rx_pop = 1'b1; tick();    // ignored on empty
    rx_push = 1'b1; tick();
    chk("R12 empty pop ignored", lsr[0], 1'b1);
    rx_pop = 1'b1; tick();
    chk("R2 cleared when empty", lsr[0], 1'b0);

    // R3 threshold zero acts as one
    rx_trig = '0;
    rx_push = 1'b1; tick();
    chk("R3 zero threshold", isr_code, 4'h4);

    // R4 single character mode
    fifo_en = 1'b0; rx_trig = CNT_W'(8);
    do_reset();
    rx_push = 1'b1; tick();
    chk("R4 fires at one", isr_code, 4'h4);
    rx_push = 1'b1; tick();
    rx_pop = 1'b1; tick();
    chk("R4 second push ignored", lsr[0], 1'b0);
    chk("R4 code", isr_code, 4'h1);
    fifo_en = 1'b1;

    // R5 overrun, R9
    ier = 3'b100;
    do_reset();
    rx_overrun = 1'b1; tick();
    chk("R5 overrun lsr", lsr, 8'h62);
    chk("R9 code", isr_code, 4'h6);
    chk("R9 irq", irq, 1'b1);
    lsr_rd = 1'b1; tick();
    chk("R5 read clears", lsr, 8'h60);
    chk("R9 code cleared", isr_code, 4'h1);

    // R8 enable edge
    ier = 3'b000;
    do_reset();
    chk("R8 disabled", isr_code, 4'h1);
    ier = 3'b010; tick();
    chk("R8 rising enable", isr_code, 4'h2);
    tx_push = 1'b1; tick();
    chk("R8 write clears", isr_code, 4'h1);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule